// File: doc/BRIEF.md
# Event Counter Group

A memory-mapped bank of event counters. Each counter has a parameterised width. It increments when three things hold in the same cycle: the event selected for it occurs, an external qualify input allows it (this is where a stream filter would plug in), and both the counter's own enable bit and the group's global enable are set.

Software reaches the block through a simple 32-bit register port.

- Counters can be loaded with any value.
- Event selection and a stream-match pattern are stored per counter. The pattern and span bit are driven out to the external filter.
- Counter enables, interrupt enables and overflow flags are each reached through a pair of set and clear addresses, so one write never disturbs a neighbouring counter.
- When a counter wraps it sets its overflow flag and keeps counting.
- A level interrupt combines overflow flags with their interrupt enables, behind a group interrupt gate.
- A read-only configuration word describes the counter count and width.
- A read-only bitmap lists the event codes the block supports.

Top module: `evt_counter_group`

## Requirements
- R1: After reset all counters, counter enables, interrupt enables, overflow flags, the global enable (0xE04 bit 0) and the interrupt gate (0xE50 bit 0) read 0, and `irq` is low.
- R2: Counter n low word sits at byte offset n*S, with S = 8 when CTR_W > 32 and S = 4 otherwise. With S = 8 the bits above 31 are at n*S + 4.
- R3: A counter adds one per clock only when all of the following hold in that cycle: the global enable is set, its counter-enable bit is set, its `ctr_qual` bit is 1, and its selected event fires. With the global enable clear, counters hold.
- R4: The event type register of counter n is at 0x400 + 4n, holding the code in bits EVT_W-1:0 and a span flag in bit 29. Code 0 fires every clock. Code k, for 0 < k < NUM_EVT, fires when `evt_hit[k]` is 1. Codes at or above NUM_EVT never fire.
- R5: Counter enables are set by writing ones to 0xC00 and cleared by writing ones to 0xC20. Both addresses read the current enables. Bit n affects only counter n, and bits 63:32 are at the +4 word.
- R6: Interrupt enables behave the same way, with set at 0xC40 and clear at 0xC60.
- R7: A counter stepping from all ones to zero sets its overflow flag and keeps counting from zero.
- R8: The overflow flags are handled as follows:
  - Writing ones to 0xC80 clears them.
  - 0xCC0 reads them, and writing ones there sets them.
  - A wrap in the same cycle as a clear leaves the flag set.
- R9: `irq` is 1 exactly when the interrupt gate is set and some counter has both its overflow flag and its interrupt enable set.
- R10: 0xE00 reads NUM_CTR-1 in bits 5:0, CTR_W-1 in bits 13:8 and GLOBAL_FLT in bit 23. Writes to it have no effect.
- R11: The words at 0xE20, 0xE24, 0xE28 and 0xE2C form a 128-bit bitmap, lowest code first. Bit k is set when k < NUM_EVT.
- R12: The stream-match register of counter n (0xA00 + 4n, 32 bits) reads back what was written. It drives `match_pat[32n+31:32n]`, while the span bit of counter n drives `match_span[n]`.
- R13: Unimplemented offsets read 0 and ignore writes. This includes counter, event-type and match slots for n >= NUM_CTR, and the +4 words of the bit-vector registers when NUM_CTR <= 32.
- R14: A software write to a counter loads the written value. It takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_hit | input | NUM_EVT | Per-cycle event occurrences, bit k for code k |
| ctr_qual | input | NUM_CTR | Per-counter qualify (filter match) |
| match_pat | output | 32*NUM_CTR | Stored stream-match pattern per counter |
| match_span | output | NUM_CTR | Stored span flag per counter |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two copies of the block.

The first has four 8-bit counters, eight event codes and the global-filter flag set. With counters this short, a 40-cycle sweep of event and qualify patterns can be checked against an arithmetic model. A wrap is also only a few increments away, which brings within reach the overflow, interrupt and same-cycle clear-versus-wrap cases.

The second has two 40-bit counters. This exercises the 8-byte stride and the split of a counter across a low and a high word, including a carry out of bit 31 and a wrap of the full 40 bits.

// File: rtl/ecg_pkg.sv
package ecg_pkg;

  localparam int WA_EVT      = 'h100;
  localparam int WA_SMR      = 'h280;
  localparam int WA_CEN_SET  = 'h300;
  localparam int WA_CEN_CLR  = 'h308;
  localparam int WA_IEN_SET  = 'h310;
  localparam int WA_IEN_CLR  = 'h318;
  localparam int WA_OVF_CLR  = 'h320;
  localparam int WA_OVF_SET  = 'h330;
  localparam int WA_CFG      = 'h380;
  localparam int WA_CTRL     = 'h381;
  localparam int WA_SUPP     = 'h388;
  localparam int WA_IRQC     = 'h394;
  localparam int SPAN_BIT    = 29;

  function automatic int ctr_stride(input int width);
    return (width > 32) ? 8 : 4;
  endfunction

  function automatic logic [31:0] cfg_word(input int nctr, input int width, input bit gflt);
    logic [31:0] r;
    r        = '0;
    r[5:0]   = 6'(nctr - 1);
    r[13:8]  = 6'(width - 1);
    r[23]    = gflt;
    return r;
  endfunction

  function automatic logic [31:0] supp_word(input int k, input int nevt);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 32; j++) r[j] = ((k * 32 + j) < nevt);
    return r;
  endfunction

  function automatic logic [31:0] pick_word(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/ecg_counter.sv
module ecg_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [31:0]  ld_data,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);

  logic         ld_any;
  logic [W-1:0] ld_next;

  assign ld_any = ld_lo | ld_hi;
  assign wrap   = inc & ~ld_any & (&value);

  generate
    if (W > 32) begin : g_wide
      always_comb begin
        ld_next = value;
        if (ld_lo) ld_next[31:0] = ld_data;
        if (ld_hi) ld_next[W-1:32] = ld_data[W-33:0];
      end
      p_load_lo_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo && !ld_hi |=> value[31:0] == $past(ld_data));
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{ld_hi, ld_data};
      assign ld_next   = ld_data[W-1:0];
      p_load_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> value == $past(ld_data[W-1:0]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (ld_any) value <= ld_next;
    else if (inc)    value <= value + W'(1);
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !ld_any |=> value == $past(value) + W'(1));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ld_any |=> $stable(value));

endmodule

// File: rtl/ecg_setclr.sv
module ecg_setclr #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_lo,
  input  logic         set_hi,
  input  logic         clr_lo,
  input  logic         clr_hi,
  input  logic [31:0]  wdata,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] q
);

  logic [N-1:0] set_m, clr_m;
  logic         unused_in;

  assign unused_in = ^{wdata, set_hi, clr_hi};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (i < 32) begin
        set_m[i] = set_lo & wdata[i % 32];
        clr_m[i] = clr_lo & wdata[i % 32];
      end else begin
        set_m[i] = set_hi & wdata[i % 32];
        clr_m[i] = clr_hi & wdata[i % 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m) | set_m | hw_set;
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_m |=> (q & $past(clr_m & ~set_m & ~hw_set)) == '0);
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_m | hw_set) |=> (q & $past(set_m | hw_set)) == $past(set_m | hw_set));

endmodule

// File: rtl/evt_counter_group.sv
module evt_counter_group
  import ecg_pkg::*;
#(
  parameter int NUM_CTR    = 8,
  parameter int CTR_W      = 32,
  parameter int NUM_EVT    = 8,
  parameter int EVT_W      = 16,
  parameter bit GLOBAL_FLT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_EVT-1:0]    evt_hit,
  input  logic [NUM_CTR-1:0]    ctr_qual,
  output logic [NUM_CTR*32-1:0] match_pat,
  output logic [NUM_CTR-1:0]    match_span,
  output logic                  irq
);

  localparam int STRIDE = ctr_stride(CTR_W);
  localparam logic [31:0] CFG_VAL = cfg_word(NUM_CTR, CTR_W, GLOBAL_FLT);

  logic [CTR_W-1:0] ctr_val [NUM_CTR];
  logic [EVT_W-1:0] evt_code [NUM_CTR];
  logic [31:0]      smr [NUM_CTR];
  logic [NUM_CTR-1:0] ld_lo, ld_hi, ctr_inc, ctr_wrap, evt_fire;
  logic [NUM_CTR-1:0] cen_q, ien_q, ovf_q;
  logic glob_en, irq_en;

  // address decode
  int   wa, c_idx;
  logic c_hi, c_ok;
  logic unused_addr;

  assign unused_addr = ^bus_addr[1:0];
  assign wa    = int'(bus_addr[11:2]);
  assign c_idx = (STRIDE == 8) ? (wa >> 1) : wa;
  assign c_hi  = (STRIDE == 8) && bus_addr[2];
  assign c_ok  = (wa < WA_EVT) && (c_idx < NUM_CTR);

  function automatic logic wr_at(input int a);
    return bus_we && (wa == a);
  endfunction

  // per-counter slices
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
      assign ld_lo[gi] = bus_we && c_ok && (c_idx == gi) && !c_hi;
      assign ld_hi[gi] = bus_we && c_ok && (c_idx == gi) && c_hi;

      always_comb begin
        evt_fire[gi] = (evt_code[gi] == '0);
        for (int k = 1; k < NUM_EVT; k++)
          if (evt_code[gi] == EVT_W'(k) && evt_hit[k]) evt_fire[gi] = 1'b1;
      end

      assign ctr_inc[gi] = glob_en & cen_q[gi] & ctr_qual[gi] & evt_fire[gi];

      ecg_counter #(.W(CTR_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ld_lo[gi]),
        .ld_hi   (ld_hi[gi]),
        .ld_data (bus_wdata),
        .inc     (ctr_inc[gi]),
        .value   (ctr_val[gi]),
        .wrap    (ctr_wrap[gi])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          evt_code[gi]   <= '0;
          match_span[gi] <= 1'b0;
          smr[gi]        <= '0;
        end else begin
          if (wr_at(WA_EVT + gi)) begin
            evt_code[gi]   <= bus_wdata[EVT_W-1:0];
            match_span[gi] <= bus_wdata[SPAN_BIT];
          end
          if (wr_at(WA_SMR + gi)) smr[gi] <= bus_wdata;
        end
      end

      assign match_pat[gi*32 +: 32] = smr[gi];

      p_wrap_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_wrap[gi] |=> ovf_q[gi]);
      p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en && !ld_lo[gi] && !ld_hi[gi] |=> $stable(ctr_val[gi]));
    end
  endgenerate

  ecg_setclr #(.N(NUM_CTR)) u_cen (
    .clk(clk), .rst_n(rst_n),
    .set_lo(wr_at(WA_CEN_SET)), .set_hi(wr_at(WA_CEN_SET + 1)),
    .clr_lo(wr_at(WA_CEN_CLR)), .clr_hi(wr_at(WA_CEN_CLR + 1)),
    .wdata(bus_wdata), .hw_set('0), .q(cen_q)
  );

  ecg_setclr #(.N(NUM_CTR)) u_ien (
    .clk(clk), .rst_n(rst_n),
    .set_lo(wr_at(WA_IEN_SET)), .set_hi(wr_at(WA_IEN_SET + 1)),
    .clr_lo(wr_at(WA_IEN_CLR)), .clr_hi(wr_at(WA_IEN_CLR + 1)),
    .wdata(bus_wdata), .hw_set('0), .q(ien_q)
  );

  ecg_setclr #(.N(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n),
    .set_lo(wr_at(WA_OVF_SET)), .set_hi(wr_at(WA_OVF_SET + 1)),
    .clr_lo(wr_at(WA_OVF_CLR)), .clr_hi(wr_at(WA_OVF_CLR + 1)),
    .wdata(bus_wdata), .hw_set(ctr_wrap), .q(ovf_q)
  );

  // group control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (wr_at(WA_CTRL)) glob_en <= bus_wdata[0];
      if (wr_at(WA_IRQC)) irq_en  <= bus_wdata[0];
    end
  end

  assign irq = irq_en & |(ovf_q & ien_q);

  // read mux
  logic [31:0] rd_mux;
  logic        rd_hi;
  assign rd_hi = bus_addr[2];

  always_comb begin
    rd_mux = '0;
    if (c_ok) begin
      for (int i = 0; i < NUM_CTR; i++)
        if (c_idx == i) rd_mux = pick_word(64'(ctr_val[i]), c_hi);
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (wa == WA_EVT + i) rd_mux = 32'(evt_code[i]) | (32'(match_span[i]) << SPAN_BIT);
      if (wa == WA_SMR + i) rd_mux = smr[i];
    end
    if (NUM_CTR > 32 || !rd_hi) begin
      if (wa == WA_CEN_SET || wa == WA_CEN_SET + 1 ||
          wa == WA_CEN_CLR || wa == WA_CEN_CLR + 1) rd_mux = pick_word(64'(cen_q), rd_hi);
      if (wa == WA_IEN_SET || wa == WA_IEN_SET + 1 ||
          wa == WA_IEN_CLR || wa == WA_IEN_CLR + 1) rd_mux = pick_word(64'(ien_q), rd_hi);
      if (wa == WA_OVF_SET || wa == WA_OVF_SET + 1) rd_mux = pick_word(64'(ovf_q), rd_hi);
    end
    if (wa == WA_CFG)  rd_mux = CFG_VAL;
    if (wa == WA_CTRL) rd_mux = 32'(glob_en);
    if (wa == WA_IRQC) rd_mux = 32'(irq_en);
    for (int k = 0; k < 4; k++)
      if (wa == WA_SUPP + k) rd_mux = supp_word(k, NUM_EVT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf_q) && (|ien_q));

endmodule

// File: tb/evt_counter_group_tb.sv
`timescale 1ns/1ps
module evt_counter_group_tb;

  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // instance A: 4 x 8-bit
  logic        a_we = 0, a_re = 0;
  logic [11:0] a_addr = '0;
  logic [31:0] a_wdata = '0, a_rdata;
  logic [7:0]  a_hit = '0;
  logic [3:0]  a_qual = '0;
  logic [127:0] a_pat;
  logic [3:0]  a_span;
  logic        a_irq;

  // instance B: 2 x 40-bit
  logic        b_we = 0, b_re = 0;
  logic [11:0] b_addr = '0;
  logic [31:0] b_wdata = '0, b_rdata;
  logic [3:0]  b_hit = '0;
  logic [1:0]  b_qual = '0;
  logic [63:0] b_pat;
  logic [1:0]  b_span;
  logic        b_irq;

  evt_counter_group #(.NUM_CTR(4), .CTR_W(8), .NUM_EVT(8), .EVT_W(16), .GLOBAL_FLT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(a_we), .bus_re(a_re), .bus_addr(a_addr),
    .bus_wdata(a_wdata), .bus_rdata(a_rdata), .evt_hit(a_hit), .ctr_qual(a_qual),
    .match_pat(a_pat), .match_span(a_span), .irq(a_irq));

  evt_counter_group #(.NUM_CTR(2), .CTR_W(40), .NUM_EVT(4), .EVT_W(16), .GLOBAL_FLT(1'b0)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .bus_we(b_we), .bus_re(b_re), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .evt_hit(b_hit), .ctr_qual(b_qual),
    .match_pat(b_pat), .match_span(b_span), .irq(b_irq));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [11:0] a, input logic [31:0] d);
    if (b) begin b_we = 1; b_addr = a; b_wdata = d; end
    else   begin a_we = 1; a_addr = a; a_wdata = d; end
    @(posedge clk); @(negedge clk);
    a_we = 0; b_we = 0;
  endtask

  task automatic rd(input bit b, input logic [11:0] a, output logic [31:0] d);
    if (b) begin b_re = 1; b_addr = a; end
    else   begin a_re = 1; a_addr = a; end
    @(posedge clk); @(negedge clk);
    a_re = 0; b_re = 0;
    d = b ? b_rdata : a_rdata;
  endtask

  task automatic rchk(input bit b, input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(b, a, d);
    chk(req, $sformatf("read 0x%03h", a), 64'(d), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int codes [4];
    logic [7:0] exp_c [4];
    codes = '{0, 3, 5, 9};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rchk(0, 12'hC00, 0, "R1");
    rchk(0, 12'hC40, 0, "R1");
    rchk(0, 12'hCC0, 0, "R1");
    rchk(0, 12'hE04, 0, "R1");
    rchk(0, 12'hE50, 0, "R1");
    rchk(0, 12'h00C, 0, "R1");
    chk("R1", "irq after reset", 64'(a_irq), 0);

    // R10 configuration word, read-only
    rchk(0, 12'hE00, 32'h0080_0703, "R10");
    wr(0, 12'hE00, 32'h0);
    rchk(0, 12'hE00, 32'h0080_0703, "R10");
    rchk(1, 12'hE00, 32'h0000_2701, "R10");

    // R11 supported-event bitmap
    rchk(0, 12'hE20, 32'hFF, "R11");
    rchk(0, 12'hE24, 0, "R11");
    rchk(0, 12'hE28, 0, "R11");
    rchk(0, 12'hE2C, 0, "R11");
    rchk(1, 12'hE20, 32'hF, "R11");

    // R2 / R14 counter load and readback at stride 4
    for (int n = 0; n < 4; n++) wr(0, 12'(n * 4), 32'(n * 37 + 5));
    for (int n = 0; n < 4; n++) rchk(0, 12'(n * 4), 32'(8'(n * 37 + 5)), "R2");

    // R13 unimplemented slots
    wr(0, 12'h010, 32'h55);
    rchk(0, 12'h010, 0, "R13");
    wr(0, 12'hE10, 32'h1234);
    rchk(0, 12'hE10, 0, "R13");
    rchk(0, 12'h410, 0, "R13");
    rchk(0, 12'hA10, 0, "R13");

    // R5 counter-enable set/clear
    wr(0, 12'hC00, 32'hF);
    rchk(0, 12'hC00, 32'hF, "R5");
    wr(0, 12'hC20, 32'h5);
    rchk(0, 12'hC20, 32'hA, "R5");
    wr(0, 12'hC00, 32'hFFFF_FFF0);
    rchk(0, 12'hC00, 32'hA, "R5");
    wr(0, 12'hC04, 32'hFFFF_FFFF);
    rchk(0, 12'hC04, 0, "R13");

    // R6 interrupt-enable set/clear
    wr(0, 12'hC40, 32'h6);
    rchk(0, 12'hC40, 32'h6, "R6");
    wr(0, 12'hC60, 32'h2);
    rchk(0, 12'hC60, 32'h4, "R6");
    wr(0, 12'hC60, 32'hF);
    rchk(0, 12'hC40, 0, "R6");

    // R3 / R4 counting sweep
    for (int n = 0; n < 4; n++) begin
      wr(0, 12'(12'h400 + n * 4), 32'(codes[n]));
      wr(0, 12'(n * 4), 0);
      exp_c[n] = 0;
    end
    wr(0, 12'hC00, 32'hF);
    wr(0, 12'hE04, 1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] h;
      logic [3:0] q;
      h = 8'((i * 37) ^ (i >> 1));
      q = 4'(i * 5 + 1);
      a_hit = h; a_qual = q;
      for (int n = 0; n < 4; n++) begin
        bit f;
        f = (codes[n] == 0) ? 1'b1 : ((codes[n] < 8) ? h[codes[n]] : 1'b0);
        if (q[n] && f) exp_c[n] = exp_c[n] + 8'd1;
      end
      @(negedge clk);
    end
    a_hit = 0; a_qual = 0;
    wr(0, 12'hE04, 0);
    for (int n = 0; n < 4; n++) rchk(0, 12'(n * 4), 32'(exp_c[n]), n == 3 ? "R4" : "R3");
    // global enable off: no counting
    a_hit = 8'hFF; a_qual = 4'hF;
    repeat (10) @(negedge clk);
    a_hit = 0; a_qual = 0;
    for (int n = 0; n < 4; n++) rchk(0, 12'(n * 4), 32'(exp_c[n]), "R3");
    rchk(0, 12'hCC0, 0, "R7");

    // R7 wrap and continue
    wr(0, 12'h404, 0);
    wr(0, 12'h004, 32'hFE);
    wr(0, 12'hE04, 1);
    a_qual = 4'h2;
    repeat (3) @(negedge clk);
    a_qual = 0;
    rchk(0, 12'h004, 32'h01, "R7");
    rchk(0, 12'hCC0, 32'h2, "R7");

    // R9 interrupt gating
    wr(0, 12'hE50, 1);
    chk("R9", "irq without inten", 64'(a_irq), 0);
    wr(0, 12'hC40, 32'h2);
    chk("R9", "irq with inten and gate", 64'(a_irq), 1);
    wr(0, 12'hE50, 0);
    chk("R9", "irq gate off", 64'(a_irq), 0);
    wr(0, 12'hE50, 1);
    chk("R9", "irq gate on again", 64'(a_irq), 1);

    // R8 overflow clear/set
    wr(0, 12'hC80, 32'h2);
    rchk(0, 12'hCC0, 0, "R8");
    chk("R9", "irq after clear", 64'(a_irq), 0);
    wr(0, 12'hCC0, 32'h4);
    rchk(0, 12'hCC0, 32'h4, "R8");
    chk("R9", "irq with masked flag", 64'(a_irq), 0);
    wr(0, 12'hC80, 32'h4);
    // wrap in same cycle as clear
    wr(0, 12'h004, 32'hFF);
    a_qual = 4'h2;
    wr(0, 12'hC80, 32'h2);
    a_qual = 0;
    rchk(0, 12'hCC0, 32'h2, "R8");
    rchk(0, 12'h004, 0, "R7");

    // R14 load beats increment
    a_qual = 4'h2;
    wr(0, 12'h004, 32'h40);
    a_qual = 0;
    rchk(0, 12'h004, 32'h40, "R14");
    wr(0, 12'hE04, 0);

    // R12 stream match and span
    wr(0, 12'hA04, 32'hDEAD_0042);
    rchk(0, 12'hA04, 32'hDEAD_0042, "R12");
    chk("R12", "match_pat[1]", 64'(a_pat[63:32]), 64'h0000_0000_DEAD_0042);
    wr(0, 12'h408, 32'h2000_0005);
    rchk(0, 12'h408, 32'h2000_0005, "R4");
    chk("R12", "match_span", 64'(a_span), 64'h4);

    // wide instance: stride 8, 40-bit wrap
    wr(1, 12'h008, 32'hFFFF_FFFF);
    wr(1, 12'h00C, 32'hFF);
    rchk(1, 12'h008, 32'hFFFF_FFFF, "R2");
    rchk(1, 12'h00C, 32'hFF, "R2");
    rchk(1, 12'h000, 0, "R2");
    rchk(1, 12'h010, 0, "R13");
    wr(1, 12'h404, 0);
    wr(1, 12'hC00, 32'h2);
    wr(1, 12'hE04, 1);
    b_qual = 2'b10;
    repeat (2) @(negedge clk);
    b_qual = 0;
    rchk(1, 12'h008, 32'h1, "R7");
    rchk(1, 12'h00C, 0, "R7");
    rchk(1, 12'hCC0, 32'h2, "R7");
    wr(1, 12'h008, 32'hFFFF_FFFF);
    wr(1, 12'h00C, 0);
    b_qual = 2'b10;
    @(negedge clk);
    b_qual = 0;
    rchk(1, 12'h00C, 32'h1, "R2");
    rchk(1, 12'h008, 0, "R2");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule